// File: doc/BRIEF.md
# Window Watchdog and Reset Sequencer

This block supervises a digital system in two ways. First, it holds a system reset low while an external comparator reports the supply out of range. Second, once the system is running, it checks that software services a window watchdog at the right time. The supply state reaches the block as two flags, one for undervoltage and one for overvoltage. When both flags clear, a reset-delay counter runs, and the reset output rises only when that delay completes.

While reset is released, a window timer runs. A service kick is a falling edge on the kick input, seen after a two-flop synchronizer. A kick is valid only if it arrives after the lower window bound and before the upper bound. A kick that comes early, or a window that expires with no kick, raises the active-low fault output for exactly the reset-delay length. During reset, an output enable releases the fault line to high impedance. Two select bits and a timeout-mode bit set the upper bound and the ratio of the lower bound to it, and one select code turns the watchdog off.

Top module: `wdt_supervisor`

## Requirements
- R1: Whenever the undervoltage or overvoltage flag is sampled high at a rising edge, `rstN` is low after that edge.
- R2: `rstN` rises at the RST_DLY-th consecutive rising edge at which both flags sample low, counted from the first such edge.
- R3: Only a falling edge on `wdiIn` counts as a kick. It is seen through a two-flop synchronizer, and a kick at or past the lower bound restarts the window from zero.
- R4: With the watchdog enabled and no kick, `wdoN` falls at the upper-bound-th rising edge after the window started. The window starts at reset release, at fault end or at a valid kick.
- R5: A kick that arrives before the lower bound drives `wdoN` low at once.
- R6: A fault holds `wdoN` low for exactly RST_DLY clock cycles. A new window then starts from zero.
- R7: Kicks are ignored while `wdoN` is low or `rstN` is low, and a rising edge on `wdiIn` never counts as a kick.
- R8: `modeLong`=1 selects an upper bound of WIN_LONG cycles, and 0 selects WIN_SHORT. The lower bound depends on `wdSel`: 2'b00 gives upper/8, 2'b01 gives upper/4, and 2'b10 gives upper/2.
- R9: `wdSel`=2'b11 disables the watchdog: no fault is raised and the window stays at zero. After re-enabling, the window starts counting from zero.
- R10: A flag that becomes active during a fault pulse ends the pulse and starts the reset sequence. While `rstN` is low, `wdoOe` is low and `wdoN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstSysN | input | 1 | Asynchronous active-low power-on reset of the logic |
| uvFlag | input | 1 | Undervoltage flag, active high |
| ovFlag | input | 1 | Overvoltage flag, active high |
| wdiIn | input | 1 | Watchdog kick input, asynchronous |
| wdSel | input | 2 | Window ratio select; 2'b11 disables the watchdog |
| modeLong | input | 1 | Upper bound select: 1 = WIN_LONG, 0 = WIN_SHORT |
| rstN | output | 1 | System reset, active low |
| wdoN | output | 1 | Watchdog fault, active low |
| wdoOe | output | 1 | Output enable for the fault line; low releases it to high impedance |

## Verification
The assertions assume that the flags are synchronous to `clk` and that `wdiIn` holds each level for at least two cycles, so that the synchronizer passes every edge. The bench drives the flags only at falling clock edges. It holds each kick level for four cycles. It changes `wdSel` and `modeLong` only around a fresh reset sequence or while the watchdog is disabled, so each window runs against a single set of bounds.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2
  } state_t;

  // strobes from control to datapath counters
  typedef struct packed {
    logic clrDly;
    logic incDly;
    logic clrWin;
    logic incWin;
  } strobe_t;

  localparam logic [1:0] SEL_OFF = 2'b11;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int RST_DLY     = 16,
  parameter int WIN_SHORT   = 64,
  parameter int WIN_LONG    = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstSysN,
  input  logic       wdiIn,
  input  logic [1:0] wdSel,
  input  logic       modeLong,
  input  strobe_t    strb,
  output logic       kickFall,
  output logic       winEarly,
  output logic       winLate,
  output logic       wdEnabled,
  output logic       dlyDone
);
  localparam int DW = $clog2(RST_DLY + 1);
  localparam int WW = $clog2(WIN_LONG + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic [DW-1:0]          dlyCnt;
  logic [WW-1:0]          winCnt;
  logic [WW-1:0]          upperB;
  logic [WW-1:0]          lowerB;

  // kick synchronizer chain
  always_ff @(posedge clk or negedge rstSysN) begin
    if (!rstSysN) syncQ[0] <= 1'b1;
    else          syncQ[0] <= wdiIn;
  end

  genvar g;
  generate
    for (g = 1; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstSysN) begin
        if (!rstSysN) syncQ[g] <= 1'b1;
        else          syncQ[g] <= syncQ[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstSysN) begin
    if (!rstSysN) prevQ <= 1'b1;
    else          prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign kickFall = prevQ & ~syncQ[SYNC_STAGES-1];

  // window bounds
  always_comb begin
    upperB = modeLong ? WW'(WIN_LONG) : WW'(WIN_SHORT);
    unique case (wdSel)
      2'b00:   lowerB = upperB >> 3;
      2'b01:   lowerB = upperB >> 2;
      2'b10:   lowerB = upperB >> 1;
      default: lowerB = '0;
    endcase
  end

  assign wdEnabled = (wdSel != SEL_OFF);
  assign winEarly  = (winCnt < lowerB);
  assign winLate   = (winCnt >= upperB - WW'(1));
  assign dlyDone   = (dlyCnt == DW'(RST_DLY - 1));

  always_ff @(posedge clk or negedge rstSysN) begin
    if (!rstSysN)         dlyCnt <= '0;
    else if (strb.clrDly) dlyCnt <= '0;
    else if (strb.incDly) dlyCnt <= dlyCnt + DW'(1);
  end

  always_ff @(posedge clk or negedge rstSysN) begin
    if (!rstSysN)         winCnt <= '0;
    else if (strb.clrWin) winCnt <= '0;
    else if (strb.incWin) winCnt <= winCnt + WW'(1);
  end

  // R3: a detected fall reflects a low input two samples earlier
  a_r3_sync_latency: assert property (@(posedge clk) disable iff (!rstSysN)
    kickFall |-> ($past(wdiIn, 2) == 1'b0));

  // R9: a cleared window reads zero on the next cycle
  a_r9_win_cleared: assert property (@(posedge clk) disable iff (!rstSysN)
    strb.clrWin |=> (winCnt == '0));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic    clk,
  input  logic    rstSysN,
  input  logic    flagAny,
  input  logic    kickFall,
  input  logic    winEarly,
  input  logic    winLate,
  input  logic    wdEnabled,
  input  logic    dlyDone,
  output strobe_t strb,
  output logic    rstN,
  output logic    wdoN,
  output logic    wdoOe
);
  state_t st, stNxt;

  always_ff @(posedge clk or negedge rstSysN) begin
    if (!rstSysN) st <= ST_RESET;
    else          st <= stNxt;
  end

  always_comb begin
    stNxt = st;
    strb  = '0;
    unique case (st)
      ST_RESET: begin
        if (flagAny) strb.clrDly = 1'b1;
        else if (dlyDone) begin
          stNxt       = ST_RUN;
          strb.clrWin = 1'b1;
        end else strb.incDly = 1'b1;
      end
      ST_RUN: begin
        if (flagAny) begin
          stNxt       = ST_RESET;
          strb.clrDly = 1'b1;
        end else if (!wdEnabled) strb.clrWin = 1'b1;
        else if (kickFall) begin
          if (winEarly) begin
            stNxt       = ST_FAULT;
            strb.clrDly = 1'b1;
          end else strb.clrWin = 1'b1;
        end else if (winLate) begin
          stNxt       = ST_FAULT;
          strb.clrDly = 1'b1;
        end else strb.incWin = 1'b1;
      end
      ST_FAULT: begin
        if (flagAny) begin
          stNxt       = ST_RESET;
          strb.clrDly = 1'b1;
        end else if (dlyDone) begin
          stNxt       = ST_RUN;
          strb.clrWin = 1'b1;
        end else strb.incDly = 1'b1;
      end
      default: begin
        stNxt       = ST_RESET;
        strb.clrDly = 1'b1;
      end
    endcase
  end

  assign rstN  = (st != ST_RESET);
  assign wdoN  = (st != ST_FAULT);
  assign wdoOe = (st != ST_RESET);

  a_r1_flag_resets: assert property (@(posedge clk) disable iff (!rstSysN)
    flagAny |=> !rstN);

  a_r2_release_after_delay: assert property (@(posedge clk) disable iff (!rstSysN)
    $rose(rstN) |-> $past(dlyDone && !flagAny));

  a_r4_fault_cause: assert property (@(posedge clk) disable iff (!rstSysN)
    $fell(wdoN) |-> $past(wdEnabled && (winLate || (kickFall && winEarly))));

  a_r6_fault_ends_on_delay: assert property (@(posedge clk) disable iff (!rstSysN)
    ($rose(wdoN) && rstN) |-> $past(dlyDone));

  a_r10_reset_from_flag: assert property (@(posedge clk) disable iff (!rstSysN)
    $fell(rstN) |-> $past(flagAny));
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdt_pkg::*;
#(
  parameter int RST_DLY   = 16,
  parameter int WIN_SHORT = 64,
  parameter int WIN_LONG  = 256
) (
  input  logic       clk,
  input  logic       rstSysN,
  input  logic       uvFlag,
  input  logic       ovFlag,
  input  logic       wdiIn,
  input  logic [1:0] wdSel,
  input  logic       modeLong,
  output logic       rstN,
  output logic       wdoN,
  output logic       wdoOe
);
  strobe_t strb;
  logic kickFall, winEarly, winLate, wdEnabled, dlyDone;

  wdt_datapath #(
    .RST_DLY    (RST_DLY),
    .WIN_SHORT  (WIN_SHORT),
    .WIN_LONG   (WIN_LONG),
    .SYNC_STAGES(2)
  ) dp_i (
    .clk      (clk),
    .rstSysN  (rstSysN),
    .wdiIn    (wdiIn),
    .wdSel    (wdSel),
    .modeLong (modeLong),
    .strb     (strb),
    .kickFall (kickFall),
    .winEarly (winEarly),
    .winLate  (winLate),
    .wdEnabled(wdEnabled),
    .dlyDone  (dlyDone)
  );

  wdt_ctrl ctrl_i (
    .clk      (clk),
    .rstSysN  (rstSysN),
    .flagAny  (uvFlag | ovFlag),
    .kickFall (kickFall),
    .winEarly (winEarly),
    .winLate  (winLate),
    .wdEnabled(wdEnabled),
    .dlyDone  (dlyDone),
    .strb     (strb),
    .rstN     (rstN),
    .wdoN     (wdoN),
    .wdoOe    (wdoOe)
  );
endmodule

// File: tb/wdt_supervisor_tb_top.sv
`timescale 1ns/1ps
module wdt_supervisor_tb_top;
  localparam int RST_DLY   = 16;
  localparam int WIN_SHORT = 64;
  localparam int WIN_LONG  = 256;

  logic clk = 1'b0;
  logic rstSysN = 1'b0;
  logic uvFlag = 1'b0, ovFlag = 1'b0, wdiIn = 1'b1, modeLong = 1'b0;
  logic [1:0] wdSel = 2'b00;
  logic rstN, wdoN, wdoOe;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wdt_supervisor #(.RST_DLY(RST_DLY), .WIN_SHORT(WIN_SHORT), .WIN_LONG(WIN_LONG)) dut_i (
    .clk(clk), .rstSysN(rstSysN), .uvFlag(uvFlag), .ovFlag(ovFlag), .wdiIn(wdiIn),
    .wdSel(wdSel), .modeLong(modeLong), .rstN(rstN), .wdoN(wdoN), .wdoOe(wdoOe));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pulse undervoltage, return at the negedge right after reset release
  task automatic doReset();
    uvFlag = 1'b1;
    waitNeg(1);
    check("R1 rstN low after flag", rstN, 0);
    check("R10 wdoOe low in reset", wdoOe, 0);
    uvFlag = 1'b0;
    for (int i = 0; i < 200 && !rstN; i++) waitNeg(1);
  endtask

  // falling edge driven after m window cycles, held four cycles
  task automatic kickAt(input int m);
    waitNeg(m);
    wdiIn = 1'b0;
    waitNeg(4);
    wdiIn = 1'b1;
  endtask

  task automatic testPowerUp();
    waitNeg(2);
    check("R10 reset state rstN", rstN, 0);
    check("R10 reset state wdoN", wdoN, 1);
    check("R10 reset state wdoOe", wdoOe, 0);
    rstSysN = 1'b1;
    waitNeg(RST_DLY - 1);
    check("R2 still in reset", rstN, 0);
    waitNeg(1);
    check("R2 released on time", rstN, 1);
    check("R2 oe on", wdoOe, 1);
  endtask

  task automatic testLateAndPulse();
    waitNeg(WIN_SHORT - 1);
    check("R4 no fault before upper", wdoN, 1);
    waitNeg(1);
    check("R4 fault at upper", wdoN, 0);
    check("R4 rstN high in fault", rstN, 1);
    waitNeg(RST_DLY - 1);
    check("R6 fault still low", wdoN, 0);
    waitNeg(1);
    check("R6 fault ends on delay", wdoN, 1);
  endtask

  task automatic testInWindow();
    for (int k = 0; k < 6; k++) begin
      kickAt(20);
      check("R3 in-window kick no fault", wdoN, 1);
    end
  endtask

  task automatic testEarly();
    doReset();
    kickAt(2);
    check("R5 early kick faults", wdoN, 0);
    waitNeg(RST_DLY);
  endtask

  task automatic testRatios();
    wdSel = 2'b10;
    doReset();
    kickAt(20);
    check("R8 half ratio early", wdoN, 0);
    wdSel = 2'b01;
    doReset();
    kickAt(10);
    check("R8 quarter ratio early", wdoN, 0);
    doReset();
    kickAt(20);
    check("R8 quarter ratio valid", wdoN, 1);
    wdSel = 2'b00;
  endtask

  task automatic testLongMode();
    modeLong = 1'b1;
    doReset();
    waitNeg(100);
    check("R8 long mode no fault at 100", wdoN, 1);
    waitNeg(WIN_LONG - 101);
    check("R8 long mode before upper", wdoN, 1);
    waitNeg(1);
    check("R8 long mode fault at upper", wdoN, 0);
    modeLong = 1'b0;
    waitNeg(RST_DLY);
  endtask

  task automatic testIgnore();
    doReset();
    waitNeg(WIN_SHORT);
    check("R7 fault entered", wdoN, 0);
    wdiIn = 1'b0;
    waitNeg(RST_DLY - 1);
    check("R7 fall during fault ignored", wdoN, 0);
    waitNeg(1);
    check("R7 fault length unchanged", wdoN, 1);
    waitNeg(30);
    wdiIn = 1'b1;
    waitNeg(WIN_SHORT - 31);
    check("R7 rising edge no kick", wdoN, 1);
    waitNeg(1);
    check("R7 late fault despite rise", wdoN, 0);
    waitNeg(RST_DLY);
  endtask

  task automatic testDisabled();
    wdSel = 2'b11;
    doReset();
    kickAt(2);
    waitNeg(3 * WIN_SHORT);
    check("R9 disabled no fault", wdoN, 1);
    wdSel = 2'b00;
    waitNeg(WIN_SHORT - 1);
    check("R9 window from zero", wdoN, 1);
    waitNeg(1);
    check("R9 fault after re-enable", wdoN, 0);
  endtask

  task automatic testAbort();
    ovFlag = 1'b1;
    waitNeg(1);
    check("R10 abort rstN", rstN, 0);
    check("R10 abort wdoN released", wdoN, 1);
    check("R10 abort wdoOe", wdoOe, 0);
    ovFlag = 1'b0;
    waitNeg(RST_DLY - 1);
    check("R2 reset after abort", rstN, 0);
    waitNeg(1);
    check("R2 release after abort", rstN, 1);
  endtask

  initial begin
    testPowerUp();
    testLateAndPulse();
    testInWindow();
    testEarly();
    testRatios();
    testLongMode();
    testIgnore();
    testDisabled();
    testAbort();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule